// File: doc/BRIEF.md
# Flash Query Response Formatter

This block forms the data word returned when a host reads a parallel flash bank that is in parameter-query mode or identifier mode. The bank is made of several identical flash devices placed side by side on the data bus. Each device may run at its full width or, for wider parts, in byte mode. The block takes the byte address and size of a read and rescales the address into an index into a parameter table of about 82 bytes, or into an identifier selector. It then copies each device's answer into every device lane of the bank, and merges several bank-width answers when the read is wider than the bank.

Bank width, device width, maximum device width, table size, table contents and the two identifier values are elaboration parameters. A command sequencer elsewhere chooses the mode through `mode_i` and pulses `rd_i` for each read. The formatted word is registered and appears one cycle later, with `valid_o` high for that cycle. Configurations that are not allowed stop elaboration. If one gets through, the logic returns zero for it.

Top module: `qry_resp_fmt`

## Requirements
- R1: The table or identifier index is the sub-query byte address shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W).
- R2: In query mode (`mode_i` = 0), an index equal to or above TBL_BYTES yields zero bytes for that sub-query.
- R3: Each DEV_W-byte device answer is copied into every device lane of the bank, starting at lane 0. In byte mode of a wider part (DEV_W = 1 < MAX_DEV_W), every byte of the bank answer carries the table byte. When DEV_W equals MAX_DEV_W, the table byte sits in the lowest byte of each device lane and the other bytes of that lane are zero.
- R4: In identifier mode (`mode_i` = 1), only the low 8 bits of the index count. Index 0 returns MFR_ID and index 1 returns DEV_ID, each as its low DEV_W bytes zero-extended to DEV_W bytes. Any other index returns zero.
- R5: A read wider than BANK_W bytes is built from sub-queries k = 0, 1, ... Sub-query k uses address `addr_i` + k*BANK_W*BANK_W, and its answer is placed at byte lane k*BANK_W.
- R6: `size_i` encodes the read size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = the full bus. Bytes above the read size are zero.
- R7: `data_o` loads the formatted word on a rising clock edge where `rd_i` is high, and holds its value otherwise. `valid_o` is high exactly in the cycle after a read strobe.
- R8: While `rst_ni` is low, `data_o` is zero and `valid_o` is low.
- R9: The default table holds 0x51, 0x52, 0x59 ("QRY") at indices 0x10 to 0x12, then the command-set code 0x0001 in low-byte-first order at indices 0x13 to 0x14. All other bytes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| mode_i | input | 1 | 0 = parameter query, 1 = identifier |
| size_i | input | 2 | Read size code |
| addr_i | input | ADDR_W | Byte address of the read |
| data_o | output | 8*BUS_BYTES | Formatted read data |
| valid_o | output | 1 | Data loaded in the previous cycle |

## Verification
The bench builds three instances that share one stimulus stream. The first is four byte-mode devices behind a 4-byte bank, with a maximum device width of 2. It checks the shift of 3 and the fourfold lane copy. The second is a 1-byte bank with the default table. It checks four-way sub-query merging and the built-in header. The third is a single 2-byte device. It checks zero-filled device lanes, 16-bit identifiers and two-way merging at stride 4. The table and identifier values in the bench differ at every index, so a wrong index or a wrong lane shows up directly. Addresses are chosen to land on the last table entry, the first entry past it, and identifier indices whose upper bits wrap.

// File: rtl/qry_pkg.sv
package qry_pkg;

  typedef enum logic {
    MODE_QUERY = 1'b0,
    MODE_IDENT = 1'b1
  } qry_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BUS  = 2'd3
  } qry_size_e;

  localparam int unsigned QRY_TBL_MAX  = 128;
  localparam int unsigned QRY_HDR_BASE = 16;

  function automatic logic [8*QRY_TBL_MAX-1:0] hdr_table();
    logic [8*QRY_TBL_MAX-1:0] t;
    t = '0;
    t[8*(QRY_HDR_BASE+0) +: 8] = 8'h51;
    t[8*(QRY_HDR_BASE+1) +: 8] = 8'h52;
    t[8*(QRY_HDR_BASE+2) +: 8] = 8'h59;
    t[8*(QRY_HDR_BASE+3) +: 8] = 8'h01;
    t[8*(QRY_HDR_BASE+4) +: 8] = 8'h00;
    return t;
  endfunction

  localparam logic [8*QRY_TBL_MAX-1:0] QRY_HDR_TABLE = hdr_table();

  function automatic int unsigned size_to_bytes(qry_size_e sz, int unsigned bus);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return (bus < 4) ? bus : 4;
      default: return bus;
    endcase
  endfunction

endpackage

// File: rtl/qry_lane_rep.sv
module qry_lane_rep #(
  parameter int unsigned SLICE_BYTES = 1,
  parameter int unsigned COPIES      = 1
) (
  input  logic [8*SLICE_BYTES-1:0]        slice_i,
  output logic [8*SLICE_BYTES*COPIES-1:0] bank_o
);
  localparam int unsigned SB = 8 * SLICE_BYTES;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    assign bank_o[c*SB +: SB] = slice_i;
  end

endmodule

// File: rtl/qry_sub_query.sv
module qry_sub_query
  import qry_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 1,
  parameter int unsigned TBL_BYTES = 82,
  parameter logic [8*TBL_BYTES-1:0] TABLE = '0,
  parameter logic [15:0] MFR_ID    = 16'h0000,
  parameter logic [15:0] DEV_ID    = 16'h0000,
  parameter int unsigned OFFSET    = 0
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  qry_mode_e           mode_i,
  output logic [8*BANK_W-1:0] resp_o
);
  localparam int unsigned SA_W      = ADDR_W + 4;
  localparam int unsigned SHIFT     = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam int unsigned TI_W      = (TBL_BYTES > 1) ? $clog2(TBL_BYTES) : 1;
  localparam int unsigned DSB       = 8 * DEV_W;
  localparam int unsigned MDB       = 8 * MAX_DEV_W;
  localparam int unsigned COPIES    = BANK_W / DEV_W;
  localparam bit          NARROW_OK = (DEV_W == MAX_DEV_W) || (DEV_W == 1 && BANK_W <= 4);

  logic [SA_W-1:0] sub_addr, idx;
  logic            in_tbl;
  logic [7:0]      tbl_arr [TBL_BYTES];
  logic [7:0]      tbl_byte;
  logic [MDB-1:0]  qry_word;
  logic [15:0]     id_sel;
  logic [DSB-1:0]  dev_slice;
  logic [8*BANK_W-1:0] bank_word;

  for (genvar g = 0; g < TBL_BYTES; g++) begin : g_tbl
    assign tbl_arr[g] = TABLE[8*g +: 8];
  end

  assign sub_addr = SA_W'(addr_i) + SA_W'(OFFSET);
  assign idx      = sub_addr >> SHIFT;
  assign in_tbl   = idx < SA_W'(TBL_BYTES);
  assign tbl_byte = in_tbl ? tbl_arr[idx[TI_W-1:0]] : 8'h00;

  // byte mode of a wider part: repeat the byte, do not zero-pad
  if (DEV_W == MAX_DEV_W) begin : g_native
    assign qry_word = MDB'(tbl_byte);
  end else begin : g_narrow
    for (genvar b = 0; b < MAX_DEV_W; b++) begin : g_rep
      assign qry_word[8*b +: 8] = tbl_byte;
    end
  end

  always_comb begin
    case (idx[7:0])
      8'd0:    id_sel = MFR_ID;
      8'd1:    id_sel = DEV_ID;
      default: id_sel = 16'h0000;
    endcase
  end

  always_comb begin
    if (mode_i == MODE_IDENT) dev_slice = DSB'(32'(id_sel));
    else                      dev_slice = DSB'(qry_word);
  end

  qry_lane_rep #(
    .SLICE_BYTES(DEV_W),
    .COPIES     (COPIES)
  ) u_rep (
    .slice_i(dev_slice),
    .bank_o (bank_word)
  );

  assign resp_o = NARROW_OK ? bank_word : '0;

endmodule

// File: rtl/qry_resp_fmt.sv
module qry_resp_fmt
  import qry_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 1,
  parameter int unsigned TBL_BYTES = 82,
  parameter logic [8*TBL_BYTES-1:0] TABLE = QRY_HDR_TABLE[8*TBL_BYTES-1:0],
  parameter logic [15:0] MFR_ID    = 16'h0089,
  parameter logic [15:0] DEV_ID    = 16'h0018
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  logic                   mode_i,
  input  logic [1:0]             size_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [8*BUS_BYTES-1:0] data_o,
  output logic                   valid_o
);
  localparam int unsigned DATA_W    = 8 * BUS_BYTES;
  localparam int unsigned NSUB      = BUS_BYTES / BANK_W;
  localparam int unsigned BANK_BITS = 8 * BANK_W;
  localparam int unsigned RB_W      = $clog2(BUS_BYTES) + 1;

  if (!(BANK_W == 1 || BANK_W == 2 || BANK_W == 4)) begin : g_bad_bank
    $error("BANK_W must be 1, 2 or 4");
  end
  if (!(DEV_W == 1 || DEV_W == 2 || DEV_W == 4)) begin : g_bad_dev
    $error("DEV_W must be 1, 2 or 4");
  end
  if (!(MAX_DEV_W == 1 || MAX_DEV_W == 2 || MAX_DEV_W == 4)) begin : g_bad_max
    $error("MAX_DEV_W must be 1, 2 or 4");
  end
  if (DEV_W > BANK_W || DEV_W > MAX_DEV_W) begin : g_bad_order
    $error("DEV_W must not exceed BANK_W or MAX_DEV_W");
  end
  if (DEV_W != MAX_DEV_W && DEV_W != 1) begin : g_bad_narrow
    $error("narrow operation only in byte mode");
  end
  if (!(BUS_BYTES == 4 || BUS_BYTES == 8) || BANK_W > BUS_BYTES) begin : g_bad_bus
    $error("BUS_BYTES must be 4 or 8 and at least BANK_W");
  end
  if (TBL_BYTES > QRY_TBL_MAX || ADDR_W < 8) begin : g_bad_tbl
    $error("table too large or address too narrow");
  end

  logic [DATA_W-1:0] raw_word, masked_word;
  logic [RB_W-1:0]   rd_bytes;
  qry_mode_e         mode;

  assign mode = qry_mode_e'(mode_i);

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    qry_sub_query #(
      .ADDR_W   (ADDR_W),
      .BANK_W   (BANK_W),
      .DEV_W    (DEV_W),
      .MAX_DEV_W(MAX_DEV_W),
      .TBL_BYTES(TBL_BYTES),
      .TABLE    (TABLE),
      .MFR_ID   (MFR_ID),
      .DEV_ID   (DEV_ID),
      .OFFSET   (k * BANK_W * BANK_W)
    ) u_sub (
      .addr_i(addr_i),
      .mode_i(mode),
      .resp_o(raw_word[k*BANK_BITS +: BANK_BITS])
    );
  end

  always_comb rd_bytes = RB_W'(size_to_bytes(qry_size_e'(size_i), BUS_BYTES));

  for (genvar j = 0; j < BUS_BYTES; j++) begin : g_mask
    assign masked_word[8*j +: 8] = (RB_W'(j) < rd_bytes) ? raw_word[8*j +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= rd_i;
      if (rd_i) data_o <= masked_word;
    end
  end

endmodule

// File: rtl/qry_resp_fmt_chk.sv
module qry_resp_fmt_chk
  import qry_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 1,
  parameter int unsigned TBL_BYTES = 82
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   rd_i,
  input logic                   mode_i,
  input logic [1:0]             size_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [8*BUS_BYTES-1:0] data_o,
  input logic                   valid_o
);
  localparam int unsigned DATA_W = 8 * BUS_BYTES;
  localparam int unsigned SA_W   = ADDR_W + 4;
  localparam int unsigned SHIFT  = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);

  logic [SA_W-1:0] idx_now;
  logic            single;

  assign idx_now = SA_W'(addr_i) >> SHIFT;
  assign single  = size_to_bytes(qry_size_e'(size_i), BUS_BYTES) <= BANK_W;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R8: assert (data_o == '0 && !valid_o)
        else $error("reset state violated");
    end
  end

  assert_valid_after_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> valid_o);

  assert_valid_only_after_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !valid_o);

  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(data_o));

  assert_byte_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && size_i == SZ_BYTE |=> data_o[DATA_W-1:8] == '0);

  assert_half_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && size_i == SZ_HALF |=> data_o[DATA_W-1:16] == '0);

  assert_beyond_table_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !mode_i && single && idx_now >= SA_W'(TBL_BYTES) |=> data_o == '0);

  assert_ident_other_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i && single && idx_now[7:0] > 8'd1 |=> data_o == '0);

endmodule

bind qry_resp_fmt qry_resp_fmt_chk #(
  .ADDR_W   (ADDR_W),
  .BUS_BYTES(BUS_BYTES),
  .BANK_W   (BANK_W),
  .DEV_W    (DEV_W),
  .MAX_DEV_W(MAX_DEV_W),
  .TBL_BYTES(TBL_BYTES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .mode_i (mode_i),
  .size_i (size_i),
  .addr_i (addr_i),
  .data_o (data_o),
  .valid_o(valid_o)
);

// File: tb/qry_resp_fmt_tb.sv
`timescale 1ns/1ps
module qry_resp_fmt_tb;
  localparam int unsigned TB_TBL = 82;
  localparam logic [15:0] TB_MFR = 16'h12C4;
  localparam logic [15:0] TB_DEV = 16'h7E3A;

  // bench table: byte i = 0x80 | i, header QRY 01 00 at 0x10..0x14
  function automatic logic [8*TB_TBL-1:0] tb_table();
    logic [8*TB_TBL-1:0] t;
    for (int i = 0; i < TB_TBL; i++) t[8*i +: 8] = 8'h80 | 8'(i);
    t[8*16 +: 8] = 8'h51;
    t[8*17 +: 8] = 8'h52;
    t[8*18 +: 8] = 8'h59;
    t[8*19 +: 8] = 8'h01;
    t[8*20 +: 8] = 8'h00;
    return t;
  endfunction
  localparam logic [8*TB_TBL-1:0] TB_TABLE = tb_table();

  typedef struct packed {
    logic [3:0]  req;
    logic        mode;
    logic [1:0]  size;
    logic [11:0] addr;
    logic [31:0] exp_a;
    logic [31:0] exp_n;
    logic [31:0] exp_w;
  } vec_t;

  // a: bank 4, dev 1, max 2; n: bank 1, default table; w: bank 2, dev 2
  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'd5, 1'b0, 2'd2, 12'h080, 32'h51515151, 32'h00000000, 32'h00C200C0}, // R5 R3
    '{4'd1, 1'b0, 2'd2, 12'h010, 32'h82828282, 32'h01595251, 32'h008A0088}, // R1 R9
    '{4'd6, 1'b0, 2'd1, 12'h011, 32'h00008282, 32'h00005952, 32'h00000088}, // R6
    '{4'd6, 1'b0, 2'd0, 12'h098, 32'h00000001, 32'h00000000, 32'h000000CC}, // R6
    '{4'd2, 1'b0, 2'd2, 12'h290, 32'h00000000, 32'h00000000, 32'h00000000}, // R2 first past end
    '{4'd2, 1'b0, 2'd2, 12'h288, 32'hD1D1D1D1, 32'h00000000, 32'h00000000}, // R2 last entry
    '{4'd9, 1'b0, 2'd2, 12'h00F, 32'h81818181, 32'h59525100, 32'h00890087}, // R9 R5
    '{4'd2, 1'b0, 2'd2, 12'h0A2, 32'h00000000, 32'h00000000, 32'h000000D1}, // R2 merge over end
    '{4'd4, 1'b1, 2'd2, 12'h000, 32'hC4C4C4C4, 32'h00003AC4, 32'h000012C4}, // R4
    '{4'd4, 1'b1, 2'd2, 12'h002, 32'hC4C4C4C4, 32'h00000000, 32'h00007E3A}, // R4
    '{4'd4, 1'b1, 2'd2, 12'h008, 32'h3A3A3A3A, 32'h00000000, 32'h00000000}, // R4 R3
    '{4'd4, 1'b1, 2'd1, 12'h010, 32'h00000000, 32'h00000000, 32'h00000000}, // R4 lock index
    '{4'd4, 1'b1, 2'd2, 12'h800, 32'hC4C4C4C4, 32'h00003AC4, 32'h000012C4}, // R4 wrap low 8
    '{4'd6, 1'b1, 2'd0, 12'h001, 32'h000000C4, 32'h0000003A, 32'h000000C4}, // R6
    '{4'd4, 1'b1, 2'd2, 12'h808, 32'h3A3A3A3A, 32'h00000000, 32'h00000000}  // R4 wrap low 8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [11:0] addr_i = '0;
  logic [31:0] dat_a, dat_n, dat_w;
  logic        val_a, val_n, val_w;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  qry_resp_fmt #(
    .ADDR_W(12), .BUS_BYTES(4), .BANK_W(4), .DEV_W(1), .MAX_DEV_W(2),
    .TBL_BYTES(TB_TBL), .TABLE(TB_TABLE), .MFR_ID(TB_MFR), .DEV_ID(TB_DEV)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .mode_i(mode_i),
    .size_i(size_i), .addr_i(addr_i), .data_o(dat_a), .valid_o(val_a)
  );

  qry_resp_fmt #(
    .ADDR_W(12), .BUS_BYTES(4), .BANK_W(1), .DEV_W(1), .MAX_DEV_W(1),
    .TBL_BYTES(TB_TBL), .MFR_ID(TB_MFR), .DEV_ID(TB_DEV)
  ) u_dut_n (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .mode_i(mode_i),
    .size_i(size_i), .addr_i(addr_i), .data_o(dat_n), .valid_o(val_n)
  );

  qry_resp_fmt #(
    .ADDR_W(12), .BUS_BYTES(4), .BANK_W(2), .DEV_W(2), .MAX_DEV_W(2),
    .TBL_BYTES(TB_TBL), .TABLE(TB_TABLE), .MFR_ID(TB_MFR), .DEV_ID(TB_DEV)
  ) u_dut_w (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .mode_i(mode_i),
    .size_i(size_i), .addr_i(addr_i), .data_o(dat_w), .valid_o(val_w)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic m, input logic [1:0] s, input logic [11:0] a);
    @(negedge clk_i);
    mode_i = m; size_i = s; addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 reset data a", dat_a, 32'h0);
    chk("R8 reset data n", dat_n, 32'h0);
    chk("R8 reset valid", {29'd0, val_a, val_n, val_w}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 no valid without strobe", {29'd0, val_a, val_n, val_w}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      do_read(VECS[v].mode, VECS[v].size, VECS[v].addr);
      chk($sformatf("R%0d vec %0d a", VECS[v].req, v), dat_a, VECS[v].exp_a);
      chk($sformatf("R%0d vec %0d n", VECS[v].req, v), dat_n, VECS[v].exp_n);
      chk($sformatf("R%0d vec %0d w", VECS[v].req, v), dat_w, VECS[v].exp_w);
    end

    // R7 valid pulse and hold after the last vector
    chk("R7 valid after strobe", {29'd0, val_a, val_n, val_w}, 32'h7);
    @(negedge clk_i);
    mode_i = 1'b0; size_i = 2'd2; addr_i = 12'h010;
    @(negedge clk_i);
    chk("R7 valid drops", {29'd0, val_a, val_n, val_w}, 32'h0);
    chk("R7 hold a", dat_a, 32'h3A3A3A3A);
    chk("R7 hold n", dat_n, 32'h00000000);

    // R6 size code 3 reads the full bus
    do_read(1'b0, 2'd3, 12'h010);
    chk("R6 full bus a", dat_a, 32'h82828282);
    chk("R6 full bus n", dat_n, 32'h01595251);
    chk("R6 full bus w", dat_w, 32'h008A0088);

    // R8 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R8 async clear a", dat_a, 32'h0);
    chk("R8 async clear w", dat_w, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected done");
      summary();
      $finish;
    end
  end

endmodule